// File: doc/BRIEF.md
# Exception Pending and Active Status Tracker

This block keeps the pending and active state of three fixed system exceptions (non-maskable interrupt at vector 2, deferred service call at vector 14, periodic tick at vector 15) and of `NUM_EXT` external interrupt lines numbered from vector 16 upward. Requests arrive as one-cycle pulses on per-line inputs or as writes from software. Every cycle the block reports the pending vector to take next. Priority is reduced to a single rule: the lowest vector number wins.

The core signals acknowledge with a vector number when it takes an exception. The vector moves from pending to active, and the vector that was active before is kept on a small nesting stack. A complete strobe carrying the active vector returns the core to the previous level.

Software reaches the block through a two-register port. The control/state register sets and clears pending bits in pairs, with set taking precedence. It reads back a packed status word. The trigger register pends an external line by its line number.

Top module: `exc_status_tracker`

## Requirements
- R1: After reset nothing is pending or active. The control/state readback is 0x0000_0800, with only the return-to-base bit set, and `pend_vec_o` is 0.
- R2: A control/state write with bit 31 set makes vector 2 pending. No write clears it.
- R3: A control/state write with bit 28 set makes vector 14 pending. A write with bit 27 set and bit 28 clear clears it. When both bits are set, the set wins.
- R4: A control/state write with bit 26 set makes vector 15 pending. A write with bit 25 set and bit 26 clear clears it. When both bits are set, the set wins.
- R5: A trigger-register write (`reg_sel_i`=1) makes line n pending, and so vector 16+n, where n is `reg_wdata_i[8:0]`. The other data bits are ignored. A number n >= `NUM_EXT` changes nothing.
- R6: A one-cycle pulse on `ext_req_i[n]` makes line n pending, and so vector 16+n.
- R7: The reported pending vector is the lowest-numbered pending vector, or 0 when nothing is pending. It appears on `pend_vec_o` and in readback bits [20:12].
- R8: An acknowledge of a vector that is pending clears its pending bit and makes it the active vector. The previously active vector goes onto the nesting stack. An acknowledge of a vector that is not pending, or with `NEST_DEPTH` levels already active, is ignored.
- R9: A complete whose vector equals the current active vector restores the previous active vector, or 0 at the last level. Any other complete is ignored.
- R10: Control/state readback (`reg_sel_i`=0) holds the active vector in [8:0] (0 when none) and a return-to-base flag in bit 11, set when at most one level is active. Bit 22 is set when any external line is pends. Bits 26, 28 and 31 hold the pending state of vectors 15, 14 and 2. Readback with `reg_sel_i`=1 is 0.
- R11: A set request in the same cycle as an accepted acknowledge of that same source leaves the source pending while it becomes active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_req_i | input | NUM_EXT | Per-line pending request pulses |
| ack_valid_i | input | 1 | Acknowledge strobe |
| ack_vec_i | input | 9 | Vector being acknowledged |
| cmpl_valid_i | input | 1 | Complete strobe |
| cmpl_vec_i | input | 9 | Vector being completed |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 selects control/state, 1 selects trigger |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data of the selected register |
| pend_vec_o | output | 9 | Lowest pending vector, 0 when none |

## Verification
The hardest situation to reach from the ports is the full nesting stack. Reaching it needs `NEST_DEPTH` distinct vectors pending at once and then acknowledged in sequence without any complete in between. The stimulus triggers several external lines through the software register and acknowledges them one after another. It then offers one more pending vector and checks that both the active vector and the pending vector are unchanged. A second hard case is an acknowledge and a new request for the same line arriving in one cycle. The bench drives both strobes in a single clock period and expects the line to be active and still pending.

// File: rtl/exc_trk_pkg.sv
package exc_trk_pkg;

    localparam int VEC_W    = 9;
    localparam int SYS_SRC  = 3;

    // Source slots; the slot order matches ascending vector order.
    localparam int SRC_NMI  = 0;
    localparam int SRC_PSV  = 1;
    localparam int SRC_TICK = 2;
    localparam int SRC_EXT0 = 3;

    localparam logic [VEC_W-1:0] VEC_NMI  = 9'd2;
    localparam logic [VEC_W-1:0] VEC_PSV  = 9'd14;
    localparam logic [VEC_W-1:0] VEC_TICK = 9'd15;
    localparam logic [VEC_W-1:0] VEC_EXT0 = 9'd16;

    // Control/state register bit positions
    localparam int B_RETBASE  = 11;
    localparam int B_PEND_LO  = 12;
    localparam int B_ANY_EXT  = 22;
    localparam int B_TICK_CLR = 25;
    localparam int B_TICK_SET = 26;
    localparam int B_PSV_CLR  = 27;
    localparam int B_PSV_SET  = 28;
    localparam int B_NMI_SET  = 31;

    function automatic logic [VEC_W-1:0] src_vector(input int idx);
        logic [VEC_W-1:0] v;
        case (idx)
            SRC_NMI:  v = VEC_NMI;
            SRC_PSV:  v = VEC_PSV;
            SRC_TICK: v = VEC_TICK;
            default:  v = VEC_EXT0 + VEC_W'(idx - SRC_EXT0);
        endcase
        return v;
    endfunction

endpackage

// File: rtl/exc_pend_bank.sv
module exc_pend_bank #(
    parameter int NSRC = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_i,
    input  logic [NSRC-1:0] clr_i,
    output logic [NSRC-1:0] pend_o
);

    logic [NSRC-1:0] pend_d, pend_q;

    // Clears are applied first, so any set in the same cycle survives.
    always_comb begin
        pend_d = (pend_q & ~clr_i) | set_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend_o = pend_q;

    // A set request is never lost, whatever the clears do.
    p_set_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((pend_o & $past(set_i)) == $past(set_i)));

endmodule

// File: rtl/exc_prio_pick.sv
module exc_prio_pick #(
    parameter int NSRC  = 11,
    localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  pend_i,
    output logic             valid_o,
    output logic [IDX_W-1:0] idx_o
);

    // Lowest slot index wins; slots are ordered by vector number.
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                valid_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end

    p_pick_is_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> pend_i[idx_o]);

    p_pick_none_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_i == '0) |-> !valid_o);

endmodule

// File: rtl/exc_nest_stack.sv
module exc_nest_stack #(
    parameter int DEPTH = 4,
    parameter int VEC_W = 9,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [VEC_W-1:0] push_vec_i,
    input  logic             pop_i,
    output logic [VEC_W-1:0] top_o,
    output logic [LVL_W-1:0] lvl_o,
    output logic             full_o
);

    typedef struct packed {
        logic [DEPTH-1:0][VEC_W-1:0] ent;
        logic [LVL_W-1:0]            lvl;
    } stk_t;

    stk_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push_i && (st_q.lvl != LVL_W'(DEPTH))) begin
            for (int k = 0; k < DEPTH; k++) begin
                if (LVL_W'(k) == st_q.lvl) st_d.ent[k] = push_vec_i;
            end
            st_d.lvl = st_q.lvl + 1'b1;
        end else if (pop_i && (st_q.lvl != '0)) begin
            st_d.lvl = st_q.lvl - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        top_o = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (LVL_W'(k + 1) == st_q.lvl) top_o = st_q.ent[k];
        end
    end

    assign lvl_o  = st_q.lvl;
    assign full_o = (st_q.lvl == LVL_W'(DEPTH));

    p_lvl_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_o <= LVL_W'(DEPTH));

    p_push_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !full_o) |=> (top_o == $past(push_vec_i)));

    p_full_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full_o) |=> $stable(top_o));

    p_pop_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && (lvl_o != '0)) |=> (lvl_o == $past(lvl_o) - 1'b1));

endmodule

// File: rtl/exc_status_tracker.sv
module exc_status_tracker
    import exc_trk_pkg::*;
#(
    parameter int NUM_EXT    = 8,
    parameter int NEST_DEPTH = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EXT-1:0] ext_req_i,
    input  logic               ack_valid_i,
    input  logic [8:0]         ack_vec_i,
    input  logic               cmpl_valid_i,
    input  logic [8:0]         cmpl_vec_i,
    input  logic               reg_wr_i,
    input  logic               reg_sel_i,
    input  logic [31:0]        reg_wdata_i,
    output logic [31:0]        reg_rdata_o,
    output logic [8:0]         pend_vec_o
);

    localparam int NSRC  = SYS_SRC + NUM_EXT;
    localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;
    localparam int LVL_W = $clog2(NEST_DEPTH + 1);

    initial begin
        if (NUM_EXT < 1 || NUM_EXT > 496) $error("NUM_EXT out of range");
        if (NEST_DEPTH < 1)               $error("NEST_DEPTH must be positive");
    end

    // Next-cycle requests gathered in one struct
    typedef struct packed {
        logic [NSRC-1:0] set;
        logic [NSRC-1:0] clr;
        logic            push;
        logic            pop;
    } req_t;

    req_t req_d;

    logic [NSRC-1:0]  pend_q;
    logic [NSRC-1:0]  ack_hit;
    logic             pick_valid;
    logic [IDX_W-1:0] pick_idx;
    logic [8:0]       act_vec;
    logic [LVL_W-1:0] nest_lvl;
    logic             nest_full;
    logic             wr_ctl, wr_trig;
    logic [31:0]      ctl_rd;

    assign wr_ctl  = reg_wr_i && !reg_sel_i;
    assign wr_trig = reg_wr_i &&  reg_sel_i;

    // Per-source decode of the acknowledge vector and set requests
    logic [NSRC-1:0] set_raw;

    assign ack_hit[SRC_NMI]  = ack_valid_i && (ack_vec_i == VEC_NMI);
    assign ack_hit[SRC_PSV]  = ack_valid_i && (ack_vec_i == VEC_PSV);
    assign ack_hit[SRC_TICK] = ack_valid_i && (ack_vec_i == VEC_TICK);
    assign set_raw[SRC_NMI]  = wr_ctl && reg_wdata_i[B_NMI_SET];
    assign set_raw[SRC_PSV]  = wr_ctl && reg_wdata_i[B_PSV_SET];
    assign set_raw[SRC_TICK] = wr_ctl && reg_wdata_i[B_TICK_SET];

    for (genvar j = 0; j < NUM_EXT; j++) begin : g_ext
        assign ack_hit[SRC_EXT0 + j] = ack_valid_i && (ack_vec_i == src_vector(SRC_EXT0 + j));
        assign set_raw[SRC_EXT0 + j] = ext_req_i[j] || (wr_trig && (reg_wdata_i[8:0] == 9'(j)));
    end

    always_comb begin
        req_d      = '0;
        req_d.set  = set_raw;
        req_d.push = ((ack_hit & pend_q) != '0) && !nest_full;
        req_d.pop  = !req_d.push && cmpl_valid_i && (nest_lvl != '0)
                     && (cmpl_vec_i == act_vec);
        req_d.clr[SRC_PSV]  = wr_ctl && reg_wdata_i[B_PSV_CLR];
        req_d.clr[SRC_TICK] = wr_ctl && reg_wdata_i[B_TICK_CLR];
        if (req_d.push) req_d.clr = req_d.clr | ack_hit;
    end

    exc_pend_bank #(.NSRC(NSRC)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (req_d.set),
        .clr_i  (req_d.clr),
        .pend_o (pend_q)
    );

    exc_prio_pick #(.NSRC(NSRC)) u_pick (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend_i  (pend_q),
        .valid_o (pick_valid),
        .idx_o   (pick_idx)
    );

    exc_nest_stack #(.DEPTH(NEST_DEPTH), .VEC_W(VEC_W)) u_nest (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (req_d.push),
        .push_vec_i (ack_vec_i),
        .pop_i      (req_d.pop),
        .top_o      (act_vec),
        .lvl_o      (nest_lvl),
        .full_o     (nest_full)
    );

    assign pend_vec_o = pick_valid ? src_vector(int'(pick_idx)) : '0;

    always_comb begin
        ctl_rd                     = '0;
        ctl_rd[8:0]                = act_vec;
        ctl_rd[B_RETBASE]          = (nest_lvl <= LVL_W'(1));
        ctl_rd[B_PEND_LO +: VEC_W] = pend_vec_o;
        ctl_rd[B_ANY_EXT]          = |pend_q[NSRC-1:SRC_EXT0];
        ctl_rd[B_TICK_SET]         = pend_q[SRC_TICK];
        ctl_rd[B_PSV_SET]          = pend_q[SRC_PSV];
        ctl_rd[B_NMI_SET]          = pend_q[SRC_NMI];
    end

    assign reg_rdata_o = reg_sel_i ? 32'd0 : ctl_rd;

    logic unused_wdata;
    assign unused_wdata = ^{reg_wdata_i[30:29], reg_wdata_i[24:9]};

    p_nmi_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && reg_wdata_i[B_NMI_SET]) |=> (pend_vec_o == VEC_NMI));

    p_psv_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && reg_wdata_i[B_PSV_CLR] && !reg_wdata_i[B_PSV_SET]) |=> !pend_q[SRC_PSV]);

    p_tick_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && reg_wdata_i[B_TICK_SET]) |=> pend_q[SRC_TICK]);

    p_trig_oob_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_trig && (reg_wdata_i[8:0] >= 9'(NUM_EXT)) && (ext_req_i == '0) && !ack_valid_i)
        |=> $stable(pend_q[NSRC-1:SRC_EXT0]));

    p_ack_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_d.push |=> (reg_sel_i || (reg_rdata_o[8:0] == $past(ack_vec_i))));

    p_idle_active_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (nest_lvl == '0) |-> (act_vec == '0 || nest_lvl != '0) && ctl_rd[B_RETBASE]);

endmodule

// File: tb/tb_exc_status_tracker.sv
`timescale 1ns/1ps
module tb_exc_status_tracker;

    localparam int NUM_EXT    = 8;
    localparam int NEST_DEPTH = 4;

    localparam logic [2:0] OP_CTL  = 3'd0;
    localparam logic [2:0] OP_TRIG = 3'd1;
    localparam logic [2:0] OP_EXT  = 3'd2;
    localparam logic [2:0] OP_ACK  = 3'd3;
    localparam logic [2:0] OP_CMPL = 3'd4;

    typedef struct packed {
        logic [2:0]  op;
        logic [31:0] arg;
        logic [31:0] exp;
    } step_t;

    function automatic logic [31:0] mk(input int act, input int rb, input int pv,
                                       input int ie, input int tk, input int ps, input int nm);
        logic [31:0] v;
        v        = '0;
        v[8:0]   = 9'(act);
        v[11]    = rb[0];
        v[20:12] = 9'(pv);
        v[22]    = ie[0];
        v[26]    = tk[0];
        v[28]    = ps[0];
        v[31]    = nm[0];
        return v;
    endfunction

    localparam int NSTEP = 20;
    localparam step_t TBL [NSTEP] = '{
        '{OP_CTL,  32'h1800_0000, mk(0, 1, 14, 0, 0, 1, 0)},  // R3 set wins
        '{OP_CTL,  32'h0400_0000, mk(0, 1, 14, 0, 1, 1, 0)},  // R4 set
        '{OP_CTL,  32'h0800_0000, mk(0, 1, 15, 0, 1, 0, 0)},  // R3 clear
        '{OP_CTL,  32'h0600_0000, mk(0, 1, 15, 0, 1, 0, 0)},  // R4 set wins
        '{OP_CTL,  32'h0200_0000, mk(0, 1, 0,  0, 0, 0, 0)},  // R4 clear
        '{OP_TRIG, 32'h0000_0005, mk(0, 1, 21, 1, 0, 0, 0)},  // R5
        '{OP_TRIG, 32'h0000_0008, mk(0, 1, 21, 1, 0, 0, 0)},  // R5 out of range
        '{OP_TRIG, 32'h0000_01FF, mk(0, 1, 21, 1, 0, 0, 0)},  // R5 out of range
        '{OP_TRIG, 32'h0000_0203, mk(0, 1, 19, 1, 0, 0, 0)},  // R5 upper bits ignored
        '{OP_EXT,  32'h0000_0001, mk(0, 1, 16, 1, 0, 0, 0)},  // R6
        '{OP_CTL,  32'h8000_0000, mk(0, 1, 2,  1, 0, 0, 1)},  // R2 R7
        '{OP_ACK,  32'd2,         mk(2, 1, 16, 1, 0, 0, 0)},  // R8
        '{OP_ACK,  32'd21,        mk(21, 0, 16, 1, 0, 0, 0)}, // R8 nest R10
        '{OP_ACK,  32'd14,        mk(21, 0, 16, 1, 0, 0, 0)}, // R8 not pending
        '{OP_CMPL, 32'd2,         mk(21, 0, 16, 1, 0, 0, 0)}, // R9 not top
        '{OP_CMPL, 32'd21,        mk(2, 1, 16, 1, 0, 0, 0)},  // R9
        '{OP_CMPL, 32'd2,         mk(0, 1, 16, 1, 0, 0, 0)},  // R9
        '{OP_ACK,  32'd16,        mk(16, 1, 19, 1, 0, 0, 0)}, // R8 R7
        '{OP_ACK,  32'd19,        mk(19, 0, 0,  0, 0, 0, 0)}, // R8 R10
        '{OP_CMPL, 32'd19,        mk(16, 1, 0,  0, 0, 0, 0)}  // R9
    };

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NUM_EXT-1:0] ext_req = '0;
    logic               ack_valid = 1'b0;
    logic [8:0]         ack_vec = '0;
    logic               cmpl_valid = 1'b0;
    logic [8:0]         cmpl_vec = '0;
    logic               reg_wr = 1'b0;
    logic               reg_sel = 1'b0;
    logic [31:0]        reg_wdata = '0;
    logic [31:0]        reg_rdata;
    logic [8:0]         pend_vec;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    exc_status_tracker #(.NUM_EXT(NUM_EXT), .NEST_DEPTH(NEST_DEPTH)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ext_req_i    (ext_req),
        .ack_valid_i  (ack_valid),
        .ack_vec_i    (ack_vec),
        .cmpl_valid_i (cmpl_valid),
        .cmpl_vec_i   (cmpl_vec),
        .reg_wr_i     (reg_wr),
        .reg_sel_i    (reg_sel),
        .reg_wdata_i  (reg_wdata),
        .reg_rdata_o  (reg_rdata),
        .pend_vec_o   (pend_vec)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Drive one strobe at a falling edge; the result is visible one period later.
    task automatic do_op(input logic [2:0] op, input logic [31:0] arg);
        @(negedge clk);
        case (op)
            OP_CTL:  begin reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = arg; end
            OP_TRIG: begin reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = arg; end
            OP_EXT:  ext_req = arg[NUM_EXT-1:0];
            OP_ACK:  begin ack_valid = 1'b1; ack_vec = arg[8:0]; end
            OP_CMPL: begin cmpl_valid = 1'b1; cmpl_vec = arg[8:0]; end
            default: ;
        endcase
        @(negedge clk);
        reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = '0; ext_req = '0;
        ack_valid = 1'b0; cmpl_valid = 1'b0;
        #0.5;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #0.5;
        chk("R1 reset readback", reg_rdata, mk(0, 1, 0, 0, 0, 0, 0));
        chk("R1 reset pend_vec", 32'(pend_vec), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int s = 0; s < NSTEP; s++) begin
            do_op(TBL[s].op, TBL[s].arg);
            chk($sformatf("R7 R10 step %0d readback", s), reg_rdata, TBL[s].exp);
            chk($sformatf("R7 step %0d pend_vec", s), 32'(pend_vec), 32'(TBL[s].exp[20:12]));
        end

        // Trigger register reads back zero (R10)
        reg_sel = 1'b1;
        #0.5;
        chk("R10 trigger readback", reg_rdata, 32'd0);
        reg_sel = 1'b0;
        do_op(OP_CMPL, 32'd16);
        chk("R9 last level", reg_rdata, mk(0, 1, 0, 0, 0, 0, 0));

        // Fill the nesting stack (R8)
        for (int l = 0; l < 5; l++) do_op(OP_TRIG, 32'(l));
        for (int l = 0; l < NEST_DEPTH; l++) do_op(OP_ACK, 32'(16 + l));
        chk("R8 full stack active", 32'(reg_rdata[8:0]), 32'd19);
        do_op(OP_ACK, 32'd20);
        chk("R8 ack when full ignored active", 32'(reg_rdata[8:0]), 32'd19);
        chk("R8 ack when full keeps pending", 32'(pend_vec), 32'd20);
        for (int l = NEST_DEPTH - 1; l >= 0; l--) do_op(OP_CMPL, 32'(16 + l));
        chk("R9 stack unwound", reg_rdata, mk(0, 1, 20, 1, 0, 0, 0));
        do_op(OP_ACK, 32'd20);
        do_op(OP_CMPL, 32'd20);
        chk("R8 drained", reg_rdata, mk(0, 1, 0, 0, 0, 0, 0));

        // Same-cycle request and acknowledge of one line (R11)
        do_op(OP_EXT, 32'h40);
        chk("R6 line 6", 32'(pend_vec), 32'd22);
        @(negedge clk);
        ack_valid = 1'b1; ack_vec = 9'd22; ext_req = 8'h40;
        @(negedge clk);
        ack_valid = 1'b0; ext_req = '0;
        #0.5;
        chk("R11 active", reg_rdata, mk(22, 1, 22, 1, 0, 0, 0));

        // NMI set and mid-run reset (R2, R1)
        do_op(OP_CTL, 32'hFFFF_FFFF);
        chk("R2 nmi pending", 32'(reg_rdata[31]), 32'd1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        #0.5;
        chk("R1 reset again", reg_rdata, mk(0, 1, 0, 0, 0, 0, 0));
        chk("R1 reset again pend_vec", 32'(pend_vec), 32'd0);
        finish_run();
    end

endmodule